// File: doc/BRIEF.md
# Variable-Frequency Phase-Accumulator Clock Source

This block is a numerically controlled oscillator for one output channel. A phase accumulator advances by an increment on every reference clock cycle while the channel runs, and its top bit forms a square wave whose frequency is the increment times 2^-16 times the reference frequency. A single-cycle strobe marks every rising edge of that square wave. A downstream pulse-width stage uses the strobe as its time base.

Software supplies a 16-bit control word as two bytes. A write to the upper half only stages that byte. A write to the lower half commits the staged upper byte and the new lower byte as one word, so the oscillator never runs on a half-updated value. Words at or above the half-range point are treated as negative numbers, and their two's-complement magnitude becomes the increment. As a result, the increment never exceeds 2^15.

Top module: `nco_clkgen`

## Requirements
- R1: While `rst` is high, on the next clock edge `sq_out` and `tick` go to 0 and the committed control word and the staged upper byte go to 0.
- R2: A clock edge with `start` low clears the phase to 0, so after that edge `sq_out` is 0 and `tick` is 0. The committed word is kept.
- R3: A write to the upper byte alone (`hi_we` high, `lo_we` low) does not change the running increment. The output keeps its previous rate until a lower-byte write.
- R4: At an edge with `lo_we` high, the word {staged upper byte, `lo_byte`} is committed. If `hi_we` is high at the same edge, `hi_byte` is used as the upper byte. The new increment is used from the following edge on.
- R5: When the committed word is below 0x8000, the phase grows by exactly that word on every running cycle.
- R6: When the committed word is 0x8000 or above, the phase grows by (0x10000 - word) mod 0x10000 on every running cycle. So 0x8000 gives 0x8000 and 0xFFFF gives 1.
- R7: The phase wraps modulo 2^16, and `sq_out` is the phase's bit 15 (registered).
- R8: `tick` is high for exactly the cycles in which `sq_out` has just changed from 0 to 1, and for no others.
- R9: For an increment W that is a power of two, `sq_out` stays high for 2^15/W cycles and low for 2^15/W cycles in every period after start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Channel run enable; low holds the phase at zero |
| hi_we | input | 1 | Stage the upper control byte |
| hi_byte | input | 8 | Upper control byte |
| lo_we | input | 1 | Write the lower byte and commit the word |
| lo_byte | input | 8 | Lower control byte |
| sq_out | output | 1 | Variable-frequency square wave |
| tick | output | 1 | One-cycle strobe on each rising edge of `sq_out` |

## Verification
A cycle model predicts both outputs for a set of control words. The words 0x0400 and 0xFC00 have the same magnitude, so they must give identical waves; this separates correct magnitude handling from a plain unsigned increment. The words 0x8000 and 0x8001 probe the edge of the negative range. The odd word 0x1235 gives a non-power-of-two step, so the phase wraps at uneven points. Separate checks cover an upper-byte write without a commit, simultaneous byte writes, dropping start while running, and a reset in mid-run. These show that staging, commit ordering and clearing work independently, and measured high and low run lengths confirm the 50% duty for power-of-two steps.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Default phase width; the control word shares it.
  localparam int PHASE_W_DEF = 16;
endpackage

// File: rtl/nco_word_reg.sv
// Two-half control word capture: the upper byte is staged, the lower-byte
// write commits the full word atomically.
module nco_word_reg #(
  parameter int WORD_W = 16,
  parameter int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_we,
  input  logic [HALF_W-1:0] hi_byte,
  input  logic              lo_we,
  input  logic [HALF_W-1:0] lo_byte,
  output logic [WORD_W-1:0] word_o
);
  logic [HALF_W-1:0] hi_stage_q;
  logic [HALF_W-1:0] hi_next;

  assign hi_next = hi_we ? hi_byte : hi_stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_stage_q <= '0;
      word_o     <= '0;
    end else begin
      hi_stage_q <= hi_next;
      if (lo_we) word_o <= {hi_next, lo_byte};
    end
  end
endmodule

// File: rtl/nco_magnitude.sv
// Signed-word interpretation: words with the top bit set contribute their
// two's-complement magnitude.
module nco_magnitude #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] inc_o
);
  always_comb begin
    if (word_i[WORD_W-1]) inc_o = ~word_i + 1'b1;
    else                  inc_o = word_i;
  end
endmodule

// File: rtl/nco_phase_acc.sv
// Phase accumulator with registered square wave and rising-edge strobe.
module nco_phase_acc #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [PHASE_W-1:0] inc_i,
  output logic               sq_o,
  output logic               tick_o
);
  localparam int MSB = PHASE_W - 1;

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_nxt;

  assign phase_nxt = phase_q + inc_i;
  assign sq_o      = phase_q[MSB];

  always_ff @(posedge clk) begin
    if (rst || !start) begin
      phase_q <= '0;
      tick_o  <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      tick_o  <= phase_nxt[MSB] & ~phase_q[MSB];
    end
  end
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen #(
  parameter int PHASE_W = nco_pkg::PHASE_W_DEF,
  parameter int HALF_W  = PHASE_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              hi_we,
  input  logic [HALF_W-1:0] hi_byte,
  input  logic              lo_we,
  input  logic [HALF_W-1:0] lo_byte,
  output logic              sq_out,
  output logic              tick
);
  logic [PHASE_W-1:0] word_q;
  logic [PHASE_W-1:0] inc_w;

  nco_word_reg #(.WORD_W(PHASE_W), .HALF_W(HALF_W)) u_word (
    .clk(clk), .rst(rst), .hi_we(hi_we), .hi_byte(hi_byte),
    .lo_we(lo_we), .lo_byte(lo_byte), .word_o(word_q)
  );

  nco_magnitude #(.WORD_W(PHASE_W)) u_mag (
    .word_i(word_q), .inc_o(inc_w)
  );

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .start(start), .inc_i(inc_w),
    .sq_o(sq_out), .tick_o(tick)
  );
endmodule

// File: rtl/nco_clkgen_chk.sv
module nco_clkgen_chk #(
  parameter int PHASE_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               hi_we,
  input logic               lo_we,
  input logic               sq_out,
  input logic               tick,
  input logic [PHASE_W-1:0] word,
  input logic [PHASE_W-1:0] inc
);
  localparam logic [PHASE_W-1:0] HALF_RANGE = {1'b1, {(PHASE_W-1){1'b0}}};

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sq_out && !tick)); // R1
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst) !start |=> (!sq_out && !tick)); // R2
  AST_HI_ONLY_HOLDS: assert property (@(posedge clk) disable iff (rst) (hi_we && !lo_we) |=> $stable(word)); // R3
  AST_INC_BOUNDED: assert property (@(posedge clk) disable iff (rst) inc <= HALF_RANGE); // R6
  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (rst) tick |-> (sq_out && !$past(sq_out))); // R8
  AST_RISE_HAS_TICK: assert property (@(posedge clk) disable iff (rst) (sq_out && !$past(sq_out)) |-> tick); // R8
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R8
endmodule

bind nco_clkgen nco_clkgen_chk #(.PHASE_W(PHASE_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .hi_we(hi_we), .lo_we(lo_we),
  .sq_out(sq_out), .tick(tick), .word(word_q), .inc(inc_w)
);

// File: tb/nco_clkgen_tb_top.sv
`timescale 1ns/1ps
module nco_clkgen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic hi_we = 1'b0;
  logic lo_we = 1'b0;
  logic [7:0] hi_byte = '0;
  logic [7:0] lo_byte = '0;
  logic sq_out, tick;

  always #4 clk = ~clk;  // 125 MHz

  nco_clkgen dut_i (
    .clk(clk), .rst(rst), .start(start), .hi_we(hi_we), .hi_byte(hi_byte),
    .lo_we(lo_we), .lo_byte(lo_byte), .sq_out(sq_out), .tick(tick)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R1";
  bit done = 1'b0;

  // Scoreboard queues
  bit    q_sq[$];
  bit    q_tk[$];
  string q_tag[$];

  // Reference state built from the requirements
  logic [7:0]  m_hi = '0;
  logic [15:0] m_word = '0;
  logic [15:0] m_phase = '0;
  logic        m_tick = 1'b0;

  function automatic logic [15:0] step_of(input logic [15:0] w);
    if (w < 16'h8000) return w;          // R5
    return 16'((17'h10000 - 17'(w)));    // R6
  endfunction

  // Driver side: predicts outputs after each edge and queues them
  always @(posedge clk) begin
    logic [7:0]  hn;
    logic [15:0] np;
    if (rst) begin
      m_hi = '0; m_word = '0; m_phase = '0; m_tick = 1'b0;
    end else begin
      hn = hi_we ? hi_byte : m_hi;
      if (!start) begin
        m_phase = '0; m_tick = 1'b0;
      end else begin
        np = m_phase + step_of(m_word);
        m_tick = np[15] & ~m_phase[15];
        m_phase = np;
      end
      if (lo_we) m_word = {hn, lo_byte};
      m_hi = hn;
    end
    q_sq.push_back(m_phase[15]);
    q_tk.push_back(m_tick);
    q_tag.push_back(cur_tag);
  end

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    if (q_sq.size() > 0) begin
      bit es, et;
      string tg;
      es = q_sq.pop_front(); et = q_tk.pop_front(); tg = q_tag.pop_front();
      n_cmp++;
      if (sq_out !== es || tick !== et) begin
        n_bad++;
        $display("FAIL %s: sq_out/tick = %b/%b expected %b/%b at %0t",
                 tg, sq_out, tick, es, et, $time);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_hi(input logic [7:0] b);
    @(negedge clk); hi_we = 1'b1; hi_byte = b;
    @(negedge clk); hi_we = 1'b0;
  endtask

  task automatic write_lo(input logic [7:0] b);
    @(negedge clk); lo_we = 1'b1; lo_byte = b;
    @(negedge clk); lo_we = 1'b0;
  endtask

  task automatic write_word(input logic [15:0] w);
    write_hi(w[15:8]);
    write_lo(w[7:0]);
  endtask

  // R9: measure high and low run lengths after a fresh start
  task automatic measure_duty(input int half, input string tg);
    int hi_n, lo_n;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;
    while (!(sq_out && tick)) @(negedge clk);
    hi_n = 0;
    while (sq_out) begin hi_n++; @(negedge clk); end
    lo_n = 0;
    while (!sq_out) begin lo_n++; @(negedge clk); end
    n_cmp++;
    if (hi_n != half || lo_n != half) begin
      n_bad++;
      $display("FAIL %s: high/low runs = %0d/%0d expected %0d/%0d", tg, hi_n, lo_n, half, half);
    end
  endtask

  // Watchdog
  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_tag = "R1"; rst = 1'b1; idle(4);
    rst = 1'b0;
    // R2: stopped channel stays quiet
    cur_tag = "R2"; idle(5);
    // R3: upper byte alone leaves word at zero, output flat
    cur_tag = "R3"; start = 1'b1; write_hi(8'h04); idle(40);
    // R4/R5: commit 0x0400
    cur_tag = "R4"; write_lo(8'h00); idle(10);
    cur_tag = "R5"; idle(150);
    cur_tag = "R9"; measure_duty(32, "R9 word 0x0400");
    // R3: staging a new upper byte while running keeps the old rate
    cur_tag = "R3"; write_hi(8'h20); idle(100);
    cur_tag = "R4"; write_lo(8'h00); idle(60);
    // R6: negative words
    cur_tag = "R6"; write_word(16'hFC00); idle(150);
    cur_tag = "R9"; measure_duty(32, "R9 word 0xFC00");
    cur_tag = "R6"; write_word(16'h8000); idle(20);
    cur_tag = "R9"; measure_duty(1, "R9 word 0x8000");
    cur_tag = "R6"; write_word(16'h8001); idle(20);
    write_word(16'hFFFF); idle(20);
    // R7: odd step wraps unevenly
    cur_tag = "R7"; write_word(16'h1235); idle(300);
    // R8: tick vs edge with a second odd step
    cur_tag = "R8"; write_word(16'h0F0F); idle(200);
    // R2: drop start mid-run
    cur_tag = "R2"; @(negedge clk); start = 1'b0; idle(6);
    @(negedge clk); start = 1'b1; idle(50);
    // R4: both halves written in the same cycle
    cur_tag = "R4";
    @(negedge clk); hi_we = 1'b1; hi_byte = 8'h02; lo_we = 1'b1; lo_byte = 8'h80;
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b0;
    idle(200);
    // R1: reset mid-run clears the word too
    cur_tag = "R1"; @(negedge clk); rst = 1'b1; idle(3);
    @(negedge clk); rst = 1'b0; idle(40);
    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule